// File: doc/BRIEF.md
# Pulse-Width Coded Dominant Bus Node

This block is one node on a shared two-wire bus that has only two legal states. In the quiet state wire A is low and wire B is high. In the active state wire A is high and wire B is low. A node carries a bit by holding the bus active for a set time. A short hold of T cycles means 0, and a long hold of 2T cycles means 1. Because any node can keep the bus active, pulses that overlap merge into the longer one. A 1 therefore dominates a 0, and the data of the winning node stays intact.

Bytes go out most significant bit first. The node raises `drive_o` to ask the external line driver to put the bus in the active state. It reads both wires back through `line_a_i` and `line_b_i`. When a sender releases after a short pulse and still sees the bus active one cycle later, another node is sending a 1. The sender then raises `lost_arb`, stops driving for the rest of the byte, and only listens. Every node decodes every byte on the bus, including its own, and presents it on `rx_byte` with a one-cycle `rx_valid`. Both wires low is illegal and is reported on `bus_err`.

Top module: `pw_bus_node`

## Requirements
- R1: After reset, `drive_o`, `tx_busy`, `rx_valid`, `lost_arb` and `bus_err` are all 0.
- R2: A `tx_start` accepted while `tx_busy` is 0 sends `tx_byte` most significant bit first. Each bit is one high run of `drive_o`, 2T cycles long for a 1 and T cycles long for a 0.
- R3: Before each pulse of a byte, the node waits until the bus has been quiet for at least T consecutive cycles. The low time of `drive_o` between two pulses of one byte is therefore at least T cycles.
- R4: The bus is active exactly when wire A is high and wire B is low. An active run of at least T + T/2 cycles decodes as 1 and a shorter run decodes as 0. After 8 decoded bits, the byte appears on `rx_byte` (first bit in bit 7) with `rx_valid` high for exactly one cycle. A node also receives its own bytes.
- R5: A sender that sees the bus still active in the first cycle after it releases sets `lost_arb`. It raises `drive_o` no more for that byte, and it drops `tx_busy`. All nodes receive the winning byte, which is the larger of the competing values. The winner's `lost_arb` stays 0.
- R6: Nodes that send identical bytes at the same time complete them without loss.
- R7: A `tx_start` while `tx_busy` is 1 is ignored: no extra byte is sent and the byte being sent is not changed.
- R8: Both wires low sets `bus_err`, which stays set. It also discards any partly received byte.
- R9: A quiet bus for 4T consecutive cycles discards any partly received byte.
- R10: An accepted `tx_start` clears `lost_arb` and `bus_err`.
- R11: `tx_busy` stays high from the cycle after an accepted start until at least T quiet cycles after the last pulse. `drive_o` is never high while `tx_busy` is 0. The values 0x00 and 0xFF are sent and received correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_start | input | 1 | Request to send `tx_byte` |
| tx_byte | input | 8 | Byte to send |
| tx_busy | output | 1 | A byte is being sent |
| line_a_i | input | 1 | Observed wire A (high in active state) |
| line_b_i | input | 1 | Observed wire B (low in active state) |
| drive_o | output | 1 | Request to hold the bus in the active state |
| rx_byte | output | 8 | Last byte decoded from the bus |
| rx_valid | output | 1 | One-cycle strobe for `rx_byte` |
| lost_arb | output | 1 | Sticky: arbitration was lost during the last byte |
| bus_err | output | 1 | Sticky: both wires were seen low |

## Verification
A wrong pulse counter shows up directly as a `drive_o` run of the wrong length. That is visible at the end of the very first pulse. A wrong bit index or shift register shows up as a wrong `rx_byte`, or as an extra or missing `rx_valid`, about one byte time later (at most about 26T cycles). A wrong arbitration check shows up within two cycles of the first differing bit. In that case the loser either keeps pulsing, which the pulse-width scoreboard catches, or it wrongly flags `lost_arb` while winning. Receiver framing faults after stray pulses or bus errors show up as an extra or corrupted byte when the next real byte is delivered.

// File: rtl/pw_bus_pkg.sv
package pw_bus_pkg;
  typedef enum logic [1:0] {
    TX_IDLE,
    TX_WAIT,
    TX_PULSE,
    TX_SETTLE
  } tx_state_e;
endpackage

// File: rtl/pw_rx.sv
module pw_rx #(
  parameter int SYM_T  = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              line_a_i,
  input  logic              line_b_i,
  input  logic              clr_err_i,
  output logic              bus_data_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_valid_o,
  output logic              err_o
);
  localparam int PMAX_I  = 4 * SYM_T;
  localparam int PW      = $clog2(PMAX_I + 1);
  localparam int BW      = $clog2(DATA_W + 1);
  localparam logic [PW-1:0] PMAX      = PW'(PMAX_I);
  localparam logic [PW-1:0] THRESH    = PW'(SYM_T + SYM_T / 2);
  localparam logic [PW-1:0] IDLE_LAST = PW'(4 * SYM_T - 1);
  localparam logic [BW-1:0] BIT_LAST  = BW'(DATA_W - 1);

  logic              samp_err;
  logic [PW-1:0]     pcnt;
  logic [PW-1:0]     idle_cnt;
  logic [BW-1:0]     bit_cnt;
  logic [DATA_W-1:0] shr;
  logic              bit_val;
  logic [DATA_W-1:0] next_shr;

  assign bit_val  = (pcnt >= THRESH);
  assign next_shr = {shr[DATA_W-2:0], bit_val};

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_data_o <= 1'b0;
      samp_err   <= 1'b0;
      pcnt       <= '0;
      idle_cnt   <= '0;
      bit_cnt    <= '0;
      shr        <= '0;
      rx_data_o  <= '0;
      rx_valid_o <= 1'b0;
      err_o      <= 1'b0;
    end else begin
      bus_data_o <= line_a_i & ~line_b_i;
      samp_err   <= ~line_a_i & ~line_b_i;
      rx_valid_o <= 1'b0;
      if (clr_err_i) err_o <= 1'b0;
      if (samp_err) begin
        // illegal state: flag it and drop any partial byte
        err_o    <= 1'b1;
        bit_cnt  <= '0;
        pcnt     <= '0;
        idle_cnt <= '0;
      end else if (bus_data_o) begin
        if (pcnt != PMAX) pcnt <= pcnt + 1'b1;
        idle_cnt <= '0;
      end else begin
        if (idle_cnt == IDLE_LAST) bit_cnt <= '0;
        else idle_cnt <= idle_cnt + 1'b1;
        if (pcnt != '0) begin
          shr  <= next_shr;
          pcnt <= '0;
          if (bit_cnt == BIT_LAST) begin
            rx_data_o  <= next_shr;
            rx_valid_o <= 1'b1;
            bit_cnt    <= '0;
          end else begin
            bit_cnt <= bit_cnt + 1'b1;
          end
        end
      end
    end
  end

  // R4: a byte strobe lasts a single cycle
  a_r4_valid_one_cycle: assert property (@(posedge clk) disable iff (rst)
    rx_valid_o |=> !rx_valid_o);
endmodule

// File: rtl/pw_tx.sv
module pw_tx
  import pw_bus_pkg::*;
#(
  parameter int SYM_T  = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              bus_data_i,
  output logic              drive_o,
  output logic              busy_o,
  output logic              lost_o
);
  localparam int LONG_T = 2 * SYM_T;
  localparam int CW     = $clog2(LONG_T + 1);
  localparam int IW     = (DATA_W > 2) ? $clog2(DATA_W) : 1;
  localparam logic [CW-1:0] SHORT_LAST = CW'(SYM_T - 1);
  localparam logic [CW-1:0] LONG_LAST  = CW'(LONG_T - 1);
  localparam logic [CW-1:0] GAP_LAST   = CW'(SYM_T - 1);

  tx_state_e         state;
  logic [CW-1:0]     cnt;
  logic [DATA_W-1:0] shr;
  logic [IW-1:0]     idx;
  logic              last;
  logic              chk;
  logic [CW-1:0]     plen_last;

  assign plen_last = shr[DATA_W-1] ? LONG_LAST : SHORT_LAST;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= TX_IDLE;
      cnt     <= '0;
      shr     <= '0;
      idx     <= '0;
      last    <= 1'b0;
      chk     <= 1'b0;
      drive_o <= 1'b0;
      busy_o  <= 1'b0;
      lost_o  <= 1'b0;
    end else begin
      case (state)
        TX_IDLE: begin
          if (start_i) begin
            shr    <= data_i;
            idx    <= IW'(DATA_W - 1);
            last   <= 1'b0;
            cnt    <= '0;
            chk    <= 1'b0;
            lost_o <= 1'b0;
            busy_o <= 1'b1;
            state  <= TX_WAIT;
          end
        end
        TX_WAIT: begin
          chk <= 1'b0;
          if (bus_data_i) begin
            // still active right after own release: a longer pulse wins
            if (chk) begin
              lost_o <= 1'b1;
              busy_o <= 1'b0;
              state  <= TX_IDLE;
            end
            cnt <= '0;
          end else if (cnt == GAP_LAST) begin
            cnt <= '0;
            if (last) begin
              busy_o <= 1'b0;
              state  <= TX_IDLE;
            end else begin
              drive_o <= 1'b1;
              state   <= TX_PULSE;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        TX_PULSE: begin
          if (cnt == plen_last) begin
            drive_o <= 1'b0;
            cnt     <= '0;
            shr     <= {shr[DATA_W-2:0], 1'b0};
            if (idx == '0) last <= 1'b1;
            else idx <= idx - 1'b1;
            state <= TX_SETTLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        TX_SETTLE: begin
          chk   <= 1'b1;
          state <= TX_WAIT;
        end
        default: state <= TX_IDLE;
      endcase
    end
  end

  // checker: length of the current drive run
  logic [CW:0] run_len;
  always_ff @(posedge clk) begin
    if (rst) run_len <= '0;
    else if (drive_o) run_len <= run_len + 1'b1;
    else run_len <= '0;
  end

  // R2: no pulse longer than the long symbol
  a_r2_pulse_bounded: assert property (@(posedge clk) disable iff (rst)
    run_len <= (CW + 1)'(LONG_T));
  // R5: a node that lost stays off the bus
  a_r5_lost_quiet: assert property (@(posedge clk) disable iff (rst)
    lost_o |=> !drive_o);
  // R11: driving only happens inside a transmission
  a_r11_drive_within_busy: assert property (@(posedge clk) disable iff (rst)
    drive_o |-> busy_o);
endmodule

// File: rtl/pw_bus_node.sv
module pw_bus_node #(
  parameter int SYM_T  = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tx_start,
  input  logic [DATA_W-1:0] tx_byte,
  output logic              tx_busy,
  input  logic              line_a_i,
  input  logic              line_b_i,
  output logic              drive_o,
  output logic [DATA_W-1:0] rx_byte,
  output logic              rx_valid,
  output logic              lost_arb,
  output logic              bus_err
);
  logic bus_data;
  logic accept;

  assign accept = tx_start & ~tx_busy;

  pw_rx #(.SYM_T(SYM_T), .DATA_W(DATA_W)) rx_i (
    .clk        (clk),
    .rst        (rst),
    .line_a_i   (line_a_i),
    .line_b_i   (line_b_i),
    .clr_err_i  (accept),
    .bus_data_o (bus_data),
    .rx_data_o  (rx_byte),
    .rx_valid_o (rx_valid),
    .err_o      (bus_err)
  );

  pw_tx #(.SYM_T(SYM_T), .DATA_W(DATA_W)) tx_i (
    .clk        (clk),
    .rst        (rst),
    .start_i    (tx_start),
    .data_i     (tx_byte),
    .bus_data_i (bus_data),
    .drive_o    (drive_o),
    .busy_o     (tx_busy),
    .lost_o     (lost_arb)
  );

  // R10: an accepted start leaves the arbitration flag clear
  a_r10_start_clears_lost: assert property (@(posedge clk) disable iff (rst)
    accept |=> !lost_arb);
endmodule

// File: tb/pw_bus_node_tb_top.sv
module pw_bus_node_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int T = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic       start_d = 1'b0, start_p = 1'b0;
  logic [7:0] byte_d = '0, byte_p = '0;
  logic       inj_data = 1'b0, inj_err = 1'b0;
  logic       busy_d, busy_p, drv_d, drv_p, rxv_d, rxv_p;
  logic       lost_d, lost_p, err_d, err_p;
  logic [7:0] rxb_d, rxb_p;
  logic       line_a, line_b;

  // wired bus: any node holds it active, error injection pulls both low
  assign line_a = (drv_d | drv_p | inj_data) & ~inj_err;
  assign line_b = ~(drv_d | drv_p | inj_data) & ~inj_err;

  pw_bus_node #(.SYM_T(T), .DATA_W(8)) dut_i (
    .clk(clk), .rst(rst), .tx_start(start_d), .tx_byte(byte_d), .tx_busy(busy_d),
    .line_a_i(line_a), .line_b_i(line_b), .drive_o(drv_d), .rx_byte(rxb_d),
    .rx_valid(rxv_d), .lost_arb(lost_d), .bus_err(err_d));

  pw_bus_node #(.SYM_T(T), .DATA_W(8)) peer_i (
    .clk(clk), .rst(rst), .tx_start(start_p), .tx_byte(byte_p), .tx_busy(busy_p),
    .line_a_i(line_a), .line_b_i(line_b), .drive_o(drv_p), .rx_byte(rxb_p),
    .rx_valid(rxv_p), .lost_arb(lost_p), .bus_err(err_p));

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0] exp_rx_d[$];
  logic [7:0] exp_rx_p[$];
  int         exp_w_d[$];

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: received bytes and pulse widths of the dut
  int  hi_run = 0;
  int  lo_run = 0;
  bit  seen_pulse = 1'b0;
  always @(negedge clk) begin
    if (!rst) begin
      if (rxv_d) begin
        if (exp_rx_d.size() == 0) chk("R4 unexpected byte at dut", 1, 0);
        else chk("R4 R5 dut received byte", rxb_d, exp_rx_d.pop_front());
      end
      if (rxv_p) begin
        if (exp_rx_p.size() == 0) chk("R4 unexpected byte at peer", 1, 0);
        else chk("R4 R5 peer received byte", rxb_p, exp_rx_p.pop_front());
      end
      if (drv_d) begin
        if (hi_run == 0 && seen_pulse && lo_run < 4 * T)
          chk("R3 gap before pulse at least T", int'(lo_run >= T), 1);
        hi_run++;
        lo_run = 0;
      end else begin
        if (hi_run != 0) begin
          if (exp_w_d.size() == 0) chk("R2 R5 unexpected pulse", hi_run, 0);
          else chk("R2 pulse width", hi_run, exp_w_d.pop_front());
          hi_run = 0;
          seen_pulse = 1'b1;
        end
        if (lo_run < 1000) lo_run++;
      end
    end
  end

  task automatic send(logic [7:0] bd, logic [7:0] bp, bit ud, bit up);
    logic [7:0] win;
    win = (ud && up) ? ((bd > bp) ? bd : bp) : (ud ? bd : bp);
    exp_rx_d.push_back(win);
    exp_rx_p.push_back(win);
    if (ud) begin
      for (int i = 7; i >= 0; i--) begin
        exp_w_d.push_back(bd[i] ? 2 * T : T);
        if (up && !bd[i] && bp[i]) break;
      end
    end
    @(negedge clk);
    start_d = ud; start_p = up; byte_d = bd; byte_p = bp;
    @(negedge clk);
    start_d = 1'b0; start_p = 1'b0;
  endtask

  task automatic wait_done();
    while (busy_d || busy_p) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic stray(int len);
    @(negedge clk);
    inj_data = 1'b1;
    repeat (len) @(negedge clk);
    inj_data = 1'b0;
    repeat (T) @(negedge clk);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 drive", drv_d, 0);
    chk("R1 busy", busy_d, 0);
    chk("R1 rx_valid", rxv_d, 0);
    chk("R1 lost", lost_d, 0);
    chk("R1 bus_err", err_d, 0);

    // single sender, mixed bits
    send(8'hA5, 8'h00, 1, 0);
    repeat (2) @(negedge clk);
    chk("R11 busy during byte", busy_d, 1);
    wait_done();
    chk("R11 busy dropped", busy_d, 0);
    chk("R5 no loss when alone", lost_d, 0);

    // boundary values
    send(8'h00, 8'h00, 1, 0); wait_done();
    send(8'hFF, 8'h00, 1, 0); wait_done();
    chk("R11 idle after 0xFF", drv_d, 0);

    // arbitration: dut loses at third bit
    send(8'h5A, 8'h6C, 1, 1); wait_done();
    chk("R5 dut lost", lost_d, 1);
    chk("R5 peer kept", lost_p, 0);

    // R10: next start clears the flag
    send(8'h11, 8'h00, 1, 0);
    @(negedge clk);
    chk("R10 lost cleared", lost_d, 0);
    wait_done();

    // arbitration: peer loses, dut wins
    send(8'hF0, 8'hE0, 1, 1); wait_done();
    chk("R5 winner flag clear", lost_d, 0);
    chk("R5 peer lost", lost_p, 1);

    // R6 identical bytes
    send(8'h3C, 8'h3C, 1, 1); wait_done();
    chk("R6 dut no loss", lost_d, 0);
    chk("R6 peer no loss", lost_p, 0);

    // R7 start while busy is ignored
    send(8'hC3, 8'h00, 1, 0);
    repeat (20) @(negedge clk);
    start_d = 1'b1; byte_d = 8'h00;
    @(negedge clk);
    start_d = 1'b0;
    chk("R7 still busy", busy_d, 1);
    wait_done();

    // R8 partial byte then illegal state: partial discarded, flag set
    stray(2 * T); stray(T); stray(2 * T);
    @(negedge clk); inj_err = 1'b1;
    repeat (2) @(negedge clk); inj_err = 1'b0;
    repeat (3) @(negedge clk);
    chk("R8 bus_err set", err_d, 1);
    chk("R8 bus_err set at peer", err_p, 1);
    send(8'h81, 8'h00, 1, 0);
    @(negedge clk);
    chk("R10 bus_err cleared", err_d, 0);
    wait_done();
    chk("R8 peer flag sticky", err_p, 1);

    // R9 partial byte then long quiet bus
    stray(2 * T); stray(T); stray(T);
    repeat (5 * T) @(negedge clk);
    send(8'h4E, 8'h00, 1, 0); wait_done();
    chk("R9 dut queue drained", exp_rx_d.size(), 0);
    chk("R9 peer queue drained", exp_rx_p.size(), 0);
    chk("R2 widths drained", exp_w_d.size(), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule